// File: doc/BRIEF.md
# Symmetrical Component Voltage Calculator

This block turns three phase-to-earth voltage phasors into their symmetrical components. Each phasor arrives as a signed 16-bit real part and a signed 16-bit imaginary part. The phasors have already been filtered to the fundamental frequency by upstream logic. A one-cycle `in_valid` pulse marks a set of three phasors. Exactly four clock cycles later, the block presents the positive sequence phasor, the negative sequence phasor and the zero sequence phasor scaled by three, together with a magnitude estimate for each one and an `out_valid` pulse.

Rotation by the operator a (the unit phasor at +120 degrees) and by a² (+240 degrees, the same as −120 degrees) uses constant Q1.15 cosine and sine multipliers. The division by three uses a Q0.16 multiplier. Each result is rounded once and saturated to the signed 16-bit output range. The magnitude estimate needs no square root. Downstream threshold logic can compare the estimates directly, for example to detect an unbalanced supply or an earth fault. A new set of phasors can be accepted on every cycle.

Top module: `seq_component_calc`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 4 clock cycles, and it is low for the first 4 cycles after reset ends.
- R2: The rotation of a phasor x+jy uses C = −16384 and S = 28378, both Q1.15. Rotation by a gives re = (C·x − S·y + 16384) >>> 15 and im = (S·x + C·y + 16384) >>> 15. Rotation by a² gives re = (C·x + S·y + 16384) >>> 15 and im = (−S·x + C·y + 16384) >>> 15. Each component is rounded once, half up, by an arithmetic shift.
- R3: The positive sequence output is sat((P·21845 + 32768) >>> 16) per component, with P = L1 + a·L2 + a²·L3 formed from the rotated values of R2.
- R4: The negative sequence output is formed the same way as R3, but from N = L1 + a²·L2 + a·L3. The phase order of L2 and L3 is swapped relative to R3.
- R5: The zero sequence output is 3·U0 = L1 + L2 + L3 per component, saturated, with no division.
- R6: Every sequence output component clamps to 32767 or −32768 when its exact value falls outside that range. It never wraps.
- R7: Each magnitude output is an unsigned 16-bit value equal to max(|re|,|im|) + floor(min(|re|,|im|)/2), computed from the saturated output phasor. |−32768| counts as 32768.
- R8: A balanced positive-sequence input (equal amplitudes, L2 lagging L1 by 120°, L3 leading L1 by 120°) yields negative and zero sequence magnitudes of at most 2.
- R9: Sets of phasors presented on consecutive cycles, or with idle gaps between them, are processed independently and come out in order.
- R10: While reset is high, all outputs are zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid set of three phasors |
| l1_re | input | 16 | Phase L1 real part, signed |
| l1_im | input | 16 | Phase L1 imaginary part, signed |
| l2_re | input | 16 | Phase L2 real part, signed |
| l2_im | input | 16 | Phase L2 imaginary part, signed |
| l3_re | input | 16 | Phase L3 real part, signed |
| l3_im | input | 16 | Phase L3 imaginary part, signed |
| out_valid | output | 1 | Result valid, 4 cycles after `in_valid` |
| pos_re | output | 16 | Positive sequence real part, signed |
| pos_im | output | 16 | Positive sequence imaginary part, signed |
| neg_re | output | 16 | Negative sequence real part, signed |
| neg_im | output | 16 | Negative sequence imaginary part, signed |
| zero_re | output | 16 | 3·U0 real part, signed |
| zero_im | output | 16 | 3·U0 imaginary part, signed |
| pos_mag | output | 16 | Positive sequence magnitude estimate, unsigned |
| neg_mag | output | 16 | Negative sequence magnitude estimate, unsigned |
| zero_mag | output | 16 | 3·U0 magnitude estimate, unsigned |

## Verification
The latency check takes for granted that `in_valid` is meaningful only once reset has been low for four edges. For that reason the stimulus holds reset for several cycles and drives data only after release. The rotation check relies on a·v + a²·v = −v holding to within one LSB. The clamp checks rely on the internal sums never exceeding the widths that full-scale inputs can produce. The stimulus therefore includes every combination of the extreme codes −32768, −1, 0 and 32767, alongside pseudo-random vectors with idle gaps and a sweep of balanced three-phase sets at amplitude 30000.

// File: rtl/seqcomp_pkg.sv
package seqcomp_pkg;

    localparam int DW  = 16;          // phasor component width
    localparam int RW  = DW + 2;      // rotated component width
    localparam int SW  = DW + 3;      // three-term sum width
    localparam int CF  = 15;          // fraction bits of rotation constants
    localparam int TF  = 16;          // fraction bits of the one-third constant
    localparam int PW  = 2 * DW + 2;  // rotation product width
    localparam int QW  = SW + TF + 5; // scaling product width
    localparam int LAT = 4;           // pipeline depth

    localparam logic signed [DW:0] ROT_COS = -17'sd16384; // cos(120 deg), Q1.15
    localparam logic signed [DW:0] ROT_SIN = 17'sd28378;  // sin(120 deg), Q1.15
    localparam logic signed [DW:0] THIRD   = 17'sd21845;  // 1/3, Q0.16

    localparam logic signed [QW-1:0] MAX_Q = QW'((1 << (DW - 1)) - 1);
    localparam logic signed [QW-1:0] MIN_Q = -MAX_Q - QW'(1);

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } phasor_t;

    typedef struct packed {
        logic signed [RW-1:0] re;
        logic signed [RW-1:0] im;
    } rot_t;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } sum_t;

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [QW-1:0] v);
        if (v > MAX_Q)      return MAX_Q[DW-1:0];
        else if (v < MIN_Q) return MIN_Q[DW-1:0];
        else                return v[DW-1:0];
    endfunction

    function automatic logic signed [DW-1:0] scale_third(input logic signed [SW-1:0] s);
        logic signed [QW-1:0] p;
        p = QW'(s) * QW'(THIRD) + QW'(1 << (TF - 1));
        return sat_dw(p >>> TF);
    endfunction

    function automatic logic [DW:0] abs_w(input logic signed [DW-1:0] v);
        logic signed [DW:0] e;
        e = (DW + 1)'(v);
        return (e < 0) ? (DW + 1)'(-e) : (DW + 1)'(e);
    endfunction

    function automatic logic [DW-1:0] mag_est(input phasor_t p);
        logic [DW:0] a, b, hi, lo, s;
        a  = abs_w(p.re);
        b  = abs_w(p.im);
        hi = (a > b) ? a : b;
        lo = (a > b) ? b : a;
        s  = hi + (lo >> 1);
        return s[DW-1:0];
    endfunction

endpackage

// File: rtl/seq_rotator.sv
module seq_rotator
    import seqcomp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phasor_t vin,
    output rot_t    fwd,   // a * vin
    output rot_t    bwd,   // a^2 * vin
    output phasor_t vdly
);
    localparam logic signed [PW-1:0] HALF = PW'(1 << (CF - 1));

    logic signed [PW-1:0] cx, cy, sx, sy;

    always_comb begin
        cx = PW'(ROT_COS) * PW'($signed(vin.re));
        cy = PW'(ROT_COS) * PW'($signed(vin.im));
        sx = PW'(ROT_SIN) * PW'($signed(vin.re));
        sy = PW'(ROT_SIN) * PW'($signed(vin.im));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd  <= '0;
            bwd  <= '0;
            vdly <= '0;
        end else begin
            fwd.re <= RW'((cx - sy + HALF) >>> CF);
            fwd.im <= RW'((sx + cy + HALF) >>> CF);
            bwd.re <= RW'((cx + sy + HALF) >>> CF);
            bwd.im <= RW'((cy - sx + HALF) >>> CF);
            vdly   <= vin;
        end
    end

    // R2: since 1 + a + a^2 = 0, the two rotations must cancel the original to within 1 LSB
    logic signed [RW+1:0] res_re, res_im;
    assign res_re = (RW + 2)'(fwd.re) + (RW + 2)'(bwd.re) + (RW + 2)'($signed(vdly.re));
    assign res_im = (RW + 2)'(fwd.im) + (RW + 2)'(bwd.im) + (RW + 2)'($signed(vdly.im));

    // R2
    rot_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (res_re >= -1) && (res_re <= 1) && (res_im >= -1) && (res_im <= 1));

endmodule

// File: rtl/seq_combiner.sv
module seq_combiner
    import seqcomp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phasor_t l1,
    input  phasor_t l2,
    input  phasor_t l3,
    input  rot_t    l2_fwd,
    input  rot_t    l2_bwd,
    input  rot_t    l3_fwd,
    input  rot_t    l3_bwd,
    output phasor_t pos_o,
    output phasor_t neg_o,
    output phasor_t zer_o
);
    localparam logic signed [SW-1:0] MAX_S = SW'((1 << (DW - 1)) - 1);

    sum_t s_pos, s_neg, s_zer;

    // stage 2: three-term sums, phase order swapped between positive and negative
    always_ff @(posedge clk) begin
        if (rst) begin
            s_pos <= '0;
            s_neg <= '0;
            s_zer <= '0;
        end else begin
            s_pos.re <= SW'($signed(l1.re)) + SW'(l2_fwd.re) + SW'(l3_bwd.re);
            s_pos.im <= SW'($signed(l1.im)) + SW'(l2_fwd.im) + SW'(l3_bwd.im);
            s_neg.re <= SW'($signed(l1.re)) + SW'(l2_bwd.re) + SW'(l3_fwd.re);
            s_neg.im <= SW'($signed(l1.im)) + SW'(l2_bwd.im) + SW'(l3_fwd.im);
            s_zer.re <= SW'($signed(l1.re)) + SW'($signed(l2.re)) + SW'($signed(l3.re));
            s_zer.im <= SW'($signed(l1.im)) + SW'($signed(l2.im)) + SW'($signed(l3.im));
        end
    end

    // stage 3: divide by three for positive/negative, clamp all
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_o <= '0;
            neg_o <= '0;
            zer_o <= '0;
        end else begin
            pos_o.re <= scale_third(s_pos.re);
            pos_o.im <= scale_third(s_pos.im);
            neg_o.re <= scale_third(s_neg.re);
            neg_o.im <= scale_third(s_neg.im);
            zer_o.re <= sat_dw(QW'(s_zer.re));
            zer_o.im <= sat_dw(QW'(s_zer.im));
        end
    end

    // R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (s_zer.re > 0) |=> ($signed(zer_o.re) > 0));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (s_zer.im > MAX_S) |=> ($signed(zer_o.im) == 16'sd32767));

    // R3
    third_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (s_pos.re < -1) |=> ($signed(pos_o.re) < 0));

endmodule

// File: rtl/seq_magnitude.sv
module seq_magnitude
    import seqcomp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  phasor_t       pin,
    output phasor_t       pout,
    output logic [DW-1:0] mag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pout <= '0;
            mag  <= '0;
        end else begin
            pout <= pin;
            mag  <= mag_est(pin);
        end
    end

    // R7: estimate never below the larger component, never above 1.5x of it
    logic [DW:0] ar, ai;
    assign ar = abs_w(pout.re);
    assign ai = abs_w(pout.im);

    // R7
    mag_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((DW + 1)'(mag) >= ar) && ((DW + 1)'(mag) >= ai) &&
        ((DW + 2)'(mag) <= (DW + 2)'(ar) + (DW + 2)'(ai)));

endmodule

// File: rtl/seq_component_calc.sv
module seq_component_calc
    import seqcomp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [15:0]   l1_re,
    input  logic signed [15:0]   l1_im,
    input  logic signed [15:0]   l2_re,
    input  logic signed [15:0]   l2_im,
    input  logic signed [15:0]   l3_re,
    input  logic signed [15:0]   l3_im,
    output logic                 out_valid,
    output logic signed [15:0]   pos_re,
    output logic signed [15:0]   pos_im,
    output logic signed [15:0]   neg_re,
    output logic signed [15:0]   neg_im,
    output logic signed [15:0]   zero_re,
    output logic signed [15:0]   zero_im,
    output logic [15:0]          pos_mag,
    output logic [15:0]          neg_mag,
    output logic [15:0]          zero_mag
);
    localparam int NPH = 3;

    phasor_t in_ph [NPH];
    phasor_t l1_d;
    rot_t    rf [NPH-1];
    rot_t    rb [NPH-1];
    phasor_t rd [NPH-1];
    phasor_t seq_c [NPH];   // 0 positive, 1 negative, 2 zero
    phasor_t seq_f [NPH];
    logic [DW-1:0] seq_m [NPH];
    logic [LAT-1:0] vpipe;

    assign in_ph[0] = {l1_re, l1_im};
    assign in_ph[1] = {l2_re, l2_im};
    assign in_ph[2] = {l3_re, l3_im};

    // stage 1: L1 delay alongside rotations of L2 and L3
    always_ff @(posedge clk) begin
        if (rst) l1_d <= '0;
        else     l1_d <= in_ph[0];
    end

    for (genvar g = 0; g < NPH - 1; g++) begin : g_rot
        seq_rotator u_rot (
            .clk  (clk),
            .rst  (rst),
            .vin  (in_ph[g+1]),
            .fwd  (rf[g]),
            .bwd  (rb[g]),
            .vdly (rd[g])
        );
    end

    // stages 2 and 3
    seq_combiner u_comb (
        .clk    (clk),
        .rst    (rst),
        .l1     (l1_d),
        .l2     (rd[0]),
        .l3     (rd[1]),
        .l2_fwd (rf[0]),
        .l2_bwd (rb[0]),
        .l3_fwd (rf[1]),
        .l3_bwd (rb[1]),
        .pos_o  (seq_c[0]),
        .neg_o  (seq_c[1]),
        .zer_o  (seq_c[2])
    );

    // stage 4
    for (genvar k = 0; k < NPH; k++) begin : g_mag
        seq_magnitude u_mag (
            .clk  (clk),
            .rst  (rst),
            .pin  (seq_c[k]),
            .pout (seq_f[k]),
            .mag  (seq_m[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[LAT-1];
    assign pos_re    = seq_f[0].re;
    assign pos_im    = seq_f[0].im;
    assign neg_re    = seq_f[1].re;
    assign neg_im    = seq_f[1].im;
    assign zero_re   = seq_f[2].re;
    assign zero_im   = seq_f[2].im;
    assign pos_mag   = seq_m[0];
    assign neg_mag   = seq_m[1];
    assign zero_mag  = seq_m[2];

    // cycles since reset, saturating at the pipeline depth
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
    end

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, 4)));

    // R1
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'(LAT)) |-> !out_valid);

endmodule

// File: tb/seq_component_calc_test.sv
`timescale 1ns/1ps
module seq_component_calc_test;

    localparam longint C_COS = -16384;
    localparam longint C_SIN = 28378;
    localparam longint C_THR = 21845;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] l1_re = '0, l1_im = '0, l2_re = '0, l2_im = '0, l3_re = '0, l3_im = '0;
    logic out_valid;
    logic signed [15:0] pos_re, pos_im, neg_re, neg_im, zero_re, zero_im;
    logic [15:0] pos_mag, neg_mag, zero_mag;

    always #2.5 clk = ~clk;

    seq_component_calc uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .l1_re(l1_re), .l1_im(l1_im), .l2_re(l2_re), .l2_im(l2_im),
        .l3_re(l3_re), .l3_im(l3_im),
        .out_valid(out_valid),
        .pos_re(pos_re), .pos_im(pos_im), .neg_re(neg_re), .neg_im(neg_im),
        .zero_re(zero_re), .zero_im(zero_im),
        .pos_mag(pos_mag), .neg_mag(neg_mag), .zero_mag(zero_mag)
    );

    typedef struct {
        int pr, pi, nr, ni, zr, zi, pm, nm, zm;
        bit ps, ns, zs;
        string tag;
    } exp_t;

    int n_chk = 0;
    int n_fail = 0;
    exp_t ring [16];
    int wr = 0, rd = 0, pend = 0;
    bit vh [4] = '{0, 0, 0, 0};

    function automatic longint rnd(input longint v, input int sh);
        return (v + (longint'(1) <<< (sh - 1))) >>> sh;
    endfunction

    function automatic bit oor(input longint v);
        return (v > 32767) || (v < -32768);
    endfunction

    function automatic int clamp(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int third(input longint s);
        return clamp(rnd(s * C_THR, 16));
    endfunction

    function automatic bit third_oor(input longint s);
        return oor(rnd(s * C_THR, 16));
    endfunction

    function automatic int mag(input int re, input int im);
        int a, b;
        a = (re < 0) ? -re : re;
        b = (im < 0) ? -im : im;
        return (a > b) ? a + b / 2 : b + a / 2;
    endfunction

    function automatic exp_t model(input int a0, a1, a2, a3, a4, a5, input string tag);
        exp_t e;
        longint f2r, f2i, b2r, b2i, f3r, f3i, b3r, b3i, spr, spi, snr, sni, szr, szi;
        f2r = rnd(C_COS * a2 - C_SIN * a3, 15);
        f2i = rnd(C_SIN * a2 + C_COS * a3, 15);
        b2r = rnd(C_COS * a2 + C_SIN * a3, 15);
        b2i = rnd(-C_SIN * a2 + C_COS * a3, 15);
        f3r = rnd(C_COS * a4 - C_SIN * a5, 15);
        f3i = rnd(C_SIN * a4 + C_COS * a5, 15);
        b3r = rnd(C_COS * a4 + C_SIN * a5, 15);
        b3i = rnd(-C_SIN * a4 + C_COS * a5, 15);
        spr = a0 + f2r + b3r;  spi = a1 + f2i + b3i;
        snr = a0 + b2r + f3r;  sni = a1 + b2i + f3i;
        szr = longint'(a0) + a2 + a4;
        szi = longint'(a1) + a3 + a5;
        e.pr = third(spr); e.pi = third(spi);
        e.nr = third(snr); e.ni = third(sni);
        e.zr = clamp(szr); e.zi = clamp(szi);
        e.ps = third_oor(spr) || third_oor(spi);
        e.ns = third_oor(snr) || third_oor(sni);
        e.zs = oor(szr) || oor(szi);
        e.pm = mag(e.pr, e.pi);
        e.nm = mag(e.nr, e.ni);
        e.zm = mag(e.zr, e.zi);
        e.tag = tag;
        return e;
    endfunction

    task automatic chk(input string req, input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input string tag, input int act, input int lim);
        n_chk++;
        if (act > lim) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected<=%0d", req, tag, act, lim);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (pend == 0) begin
            chk("R9", "unexpected result", 1, 0);
            return;
        end
        e = ring[rd];
        rd = (rd + 1) % 16;
        pend--;
        chk(e.ps ? "R6" : "R3", e.tag, int'(pos_re), e.pr);
        chk(e.ps ? "R6" : "R3", e.tag, int'(pos_im), e.pi);
        chk(e.ns ? "R6" : "R4", e.tag, int'(neg_re), e.nr);
        chk(e.ns ? "R6" : "R4", e.tag, int'(neg_im), e.ni);
        chk(e.zs ? "R6" : "R5", e.tag, int'(zero_re), e.zr);
        chk(e.zs ? "R6" : "R5", e.tag, int'(zero_im), e.zi);
        chk("R7", e.tag, int'(pos_mag), e.pm);
        chk("R7", e.tag, int'(neg_mag), e.nm);
        chk("R7", e.tag, int'(zero_mag), e.zm);
        if (e.tag == "R8") begin
            chk_le("R8", "negative magnitude", int'(neg_mag), 2);
            chk_le("R8", "zero magnitude", int'(zero_mag), 2);
        end
    endtask

    // one cycle: check outputs of the set driven four cycles ago, then drive the next one
    task automatic step(input bit v, input int a0, a1, a2, a3, a4, a5, input string tag);
        @(negedge clk);
        chk("R1", "valid delay", int'(out_valid), int'(vh[3]));
        if (out_valid) compare_out();
        vh[3] = vh[2]; vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = v;
        in_valid = v;
        l1_re = 16'(a0); l1_im = 16'(a1);
        l2_re = 16'(a2); l2_im = 16'(a3);
        l3_re = 16'(a4); l3_im = 16'(a5);
        if (v) begin
            ring[wr] = model(a0, a1, a2, a3, a4, a5, tag);
            wr = (wr + 1) % 16;
            pend++;
        end
    endtask

    function automatic int rr(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    bit [31:0] lfsr = 32'h1234_5678;
    function automatic bit [31:0] nxt(input bit [31:0] s);
        bit [31:0] x;
        x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int vals [4] = '{-32768, -1, 0, 32767};
        // R10: reset holds everything at zero even with live inputs
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            l1_re = 16'sd30000; l1_im = -16'sd20000; l2_re = 16'sd1234;
            l2_im = 16'sd32767; l3_re = -16'sd32768; l3_im = 16'sd77;
        end
        @(negedge clk);
        chk("R10", "reset out_valid", int'(out_valid), 0);
        chk("R10", "reset pos_re", int'(pos_re), 0);
        chk("R10", "reset neg_im", int'(neg_im), 0);
        chk("R10", "reset zero_re", int'(zero_re), 0);
        chk("R10", "reset pos_mag", int'(pos_mag), 0);
        chk("R10", "reset zero_mag", int'(zero_mag), 0);
        in_valid = 1'b0;
        rst = 1'b0;

        // R1: quiet pipeline right after reset
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, "R1");

        // R2: single rotated phase on L2, then on L3
        step(1, 0, 0, 16384, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 16384, 0, 0, "R2");
        step(1, 0, 0, -32768, 0, 0, 0, "R2");
        step(1, 0, 0, 12345, -321, 0, 0, "R2");
        step(1, 0, 0, 0, 0, 16384, 0, "R2");
        step(1, 0, 0, 0, 0, 0, -16384, "R2");
        step(1, 0, 0, 0, 0, 32767, 32767, "R2");
        step(0, 0, 0, 0, 0, 0, 0, "R2");

        // R6: every combination of extreme codes over all six components
        for (int i = 0; i < 4096; i++) begin
            step(1, vals[i & 3], vals[(i >> 2) & 3], vals[(i >> 4) & 3],
                 vals[(i >> 6) & 3], vals[(i >> 8) & 3], vals[(i >> 10) & 3], "R6");
        end

        // R9: pseudo-random sets with idle gaps
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] a, b, c;
            lfsr = nxt(lfsr); a = lfsr;
            lfsr = nxt(lfsr); b = lfsr;
            lfsr = nxt(lfsr); c = lfsr;
            step(c[31:30] != 2'b00,
                 int'($signed(a[15:0])), int'($signed(a[31:16])),
                 int'($signed(b[15:0])), int'($signed(b[31:16])),
                 int'($signed(c[15:0])), int'($signed(c[29:14])), "R9");
        end

        // R8: balanced positive-sequence sets around the full circle
        for (int k = 0; k < 120; k++) begin
            real th, amp, d;
            amp = 30000.0;
            d = 3.14159265358979 * 2.0 / 3.0;
            th = 3.14159265358979 * real'(k * 3) / 180.0;
            step(1, rr(amp * $cos(th)), rr(amp * $sin(th)),
                 rr(amp * $cos(th - d)), rr(amp * $sin(th - d)),
                 rr(amp * $cos(th + d)), rr(amp * $sin(th + d)), "R8");
        end

        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "R9");
        chk("R9", "results outstanding", pend, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule